// File: doc/BRIEF.md
# Selectable Multiphase Clock Generator

This block turns a fast master clock into four phase-related output waveforms. A prescaler first slows the master clock down by 1, 10 or 100 and produces a single-cycle step enable. The phase stage advances once per step, and a 2-bit mode input sets the number of phases. In two-phase mode the outputs form a complementary pair, and each signal is also copied onto a second output. Three-phase mode rotates a single high level through three outputs and holds the fourth low. Four-phase mode rotates a pair of high levels through all four outputs, which gives 50% duty cycle with quarter-period spacing.

All four outputs come straight from flip-flops clocked by the master clock, so they change only at rising edges and cannot glitch. A change in either setting restarts both the prescaler and the phase pattern from a defined starting point in which the first output is high. Downstream logic therefore never sees a pattern that belongs to neither the old mode nor the new one. Reset is synchronous and active high.

Top module: `multiphase_clkgen`

## Requirements
- R1: While `rst` is high, every rising edge loads the starting pattern of the selected mode into `ph_out`. The starting patterns are 4'b0101 for codes 00 and 11, 4'b0001 for code 01 and 4'b1001 for code 10, where `ph_out[0]` is the first output. After `rst` falls, the starting pattern is held until the first step.
- R2: `div_sel` sets the step length N to 1 master cycle for code 00, 10 cycles for code 01, 100 cycles for code 10 and 1 cycle for code 11. Each pattern is held for exactly N cycles, and `ph_out` changes at no other time.
- R3: For mode code 00, `ph_out` alternates between 4'b0101 and 4'b1010 once per step. The second output is therefore the complement of the first, the third output copies the first and the fourth copies the second, and the period is 2N.
- R4: For mode code 01, `ph_out` steps through 4'b0001, 4'b0010 and 4'b0100 and then repeats. Each of the three active outputs is high for one step in three and lags the previous output by one step. `ph_out[3]` stays low.
- R5: For mode code 10, `ph_out` steps through 4'b1001, 4'b0011, 4'b0110 and 4'b1100 and then repeats. Each output is high for two steps in four and lags the previous output by one step.
- R6: Mode code 11 behaves exactly like mode code 00.
- R7: When `mode_sel` or `div_sel` differs from its value at the previous edge, that edge loads the starting pattern of the new mode and restarts the step count. The new pattern is then held for N cycles. A restart takes precedence over a step that falls due at the same edge.
- R8: Applying the same settings again does not restart anything; the sequence continues without a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Phase count: 00 two, 01 three, 10 four, 11 two |
| div_sel | input | 2 | Prescale: 00 by 1, 01 by 10, 10 by 100, 11 by 1 |
| ph_out | output | 4 | Registered phase outputs, bit 0 is the first output |

## Verification
A settings restart and a prescaler step can fall due at the same rising edge. In that case the restart must win, and the step must not advance the freshly loaded starting pattern. The bench provokes this by ending a run exactly one cycle before a step is due and then changing the mode. At divide-by-1 it also changes the settings on every run, because every edge carries a step at that ratio. The scoreboard judges the outcome by requiring the starting pattern of the new mode to hold for a full N cycles from the change edge.

// File: rtl/mpcg_pkg.sv
package mpcg_pkg;

  typedef enum logic [1:0] {
    MODE_TWO   = 2'b00,
    MODE_THREE = 2'b01,
    MODE_FOUR  = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;

  localparam int NUM_OUT = 4;

  typedef logic [NUM_OUT-1:0] phase_t;

  function automatic phase_t start_pattern(mode_e m);
    case (m)
      MODE_THREE: return 4'b0001;
      MODE_FOUR:  return 4'b1001;
      default:    return 4'b0101;
    endcase
  endfunction

  function automatic phase_t advance_pattern(mode_e m, phase_t p);
    case (m)
      MODE_THREE: return {1'b0, p[1:0], p[2]};
      MODE_FOUR:  return {p[2:0], p[3]};
      default:    return ~p;
    endcase
  endfunction

endpackage

// File: rtl/mpcg_cfg_track.sv
module mpcg_cfg_track #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             restart
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    cfg_q <= cfg_in;
  end

  assign restart = rst | (cfg_in != cfg_q);
endmodule

// File: rtl/mpcg_prescaler.sv
module mpcg_prescaler #(
  parameter int DIV_LO  = 1,
  parameter int DIV_MID = 10,
  parameter int DIV_HI  = 100
) (
  input  logic       clk,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       step
);
  localparam int CW = $clog2(DIV_HI + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  always_comb begin
    case (div_sel)
      2'b01:   limit = CW'(DIV_MID - 1);
      2'b10:   limit = CW'(DIV_HI - 1);
      default: limit = CW'(DIV_LO - 1);
    endcase
  end

  assign step = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (restart || step) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mpcg_phase_seq.sv
module mpcg_phase_seq
  import mpcg_pkg::*;
(
  input  logic   clk,
  input  logic   restart,
  input  logic   step,
  input  mode_e  mode,
  output phase_t phase
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (restart)   phase_q <= start_pattern(mode);
    else if (step) phase_q <= advance_pattern(mode, phase_q);
  end

  assign phase = phase_q;
endmodule

// File: rtl/multiphase_clkgen.sv
module multiphase_clkgen #(
  parameter int DIV_LO  = 1,
  parameter int DIV_MID = 10,
  parameter int DIV_HI  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic [1:0] div_sel,
  output logic [3:0] ph_out
);
  import mpcg_pkg::*;

  logic   cfg_restart;
  logic   step_tick;
  phase_t phase;

  mpcg_cfg_track #(.CFG_W(4)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cfg_in  ({mode_sel, div_sel}),
    .restart (cfg_restart)
  );

  mpcg_prescaler #(
    .DIV_LO  (DIV_LO),
    .DIV_MID (DIV_MID),
    .DIV_HI  (DIV_HI)
  ) u_pre (
    .clk     (clk),
    .restart (cfg_restart),
    .div_sel (div_sel),
    .step    (step_tick)
  );

  mpcg_phase_seq u_seq (
    .clk     (clk),
    .restart (cfg_restart),
    .step    (step_tick),
    .mode    (mode_e'(mode_sel)),
    .phase   (phase)
  );

  assign ph_out = phase;
endmodule

// File: rtl/mpcg_checker.sv
module mpcg_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic [3:0] ph_out,
  input logic       tick,
  input logic       restart
);
  a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(ph_out));

  a_r3_two_phase_pair: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00 && $stable(mode_sel)) |-> (ph_out == 4'b0101 || ph_out == 4'b1010));

  a_r4_three_phase_single: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && $stable(mode_sel)) |-> (!ph_out[3] && $countones(ph_out[2:0]) == 1));

  a_r5_four_phase_pair: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && $stable(mode_sel)) |-> ($countones(ph_out) == 2));

  a_r6_alt_code_two_phase: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11 && $stable(mode_sel)) |-> (ph_out == 4'b0101 || ph_out == 4'b1010));

  a_r7_restart_first_high: assert property (@(posedge clk) disable iff (rst)
    restart |=> ph_out[0]);
endmodule

bind multiphase_clkgen mpcg_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .ph_out   (ph_out),
  .tick     (step_tick),
  .restart  (cfg_restart)
);

// File: tb/tb_multiphase_clkgen.sv
module tb_multiphase_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic [1:0] div_sel = 2'b00;
  logic [3:0] ph_out;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] cur_m = 2'b00;
  logic [1:0] cur_d = 2'b00;
  int         cur_j = 0;

  always #4 clk = ~clk;

  multiphase_clkgen dut (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .div_sel  (div_sel),
    .ph_out   (ph_out)
  );

  function automatic int ndiv(logic [1:0] d);
    if (d == 2'b01) return 10;
    if (d == 2'b10) return 100;
    return 1;
  endfunction

  function automatic logic [3:0] exp_pat(logic [1:0] m, int idx);
    if (m == 2'b01) begin
      case (idx % 3)
        0: return 4'b0001;
        1: return 4'b0010;
        default: return 4'b0100;
      endcase
    end else if (m == 2'b10) begin
      case (idx % 4)
        0: return 4'b1001;
        1: return 4'b0011;
        2: return 4'b0110;
        default: return 4'b1100;
      endcase
    end
    return (idx % 2 == 0) ? 4'b0101 : 4'b1010;
  endfunction

  function automatic string mode_tag(logic [1:0] m, logic [1:0] d);
    string s;
    case (m)
      2'b00: s = "R3";
      2'b01: s = "R4";
      2'b10: s = "R5";
      default: s = "R6";
    endcase
    if (ndiv(d) > 1) s = {s, "/R2"};
    return s;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: ph_out=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, ph_out, e);
    end
  end

  task automatic push_items(logic [1:0] m, logic [1:0] d, int j0, int n, string first_tag);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(exp_pat(m, (j0 + k) / ndiv(d)));
      tag_q.push_back(k == 0 ? first_tag : mode_tag(m, d));
    end
  endtask

  task automatic run_cfg(logic [1:0] m, logic [1:0] d, int n);
    bit fresh;
    int j0;
    @(negedge clk);
    fresh = (m != cur_m) || (d != cur_d);
    mode_sel = m;
    div_sel = d;
    j0 = fresh ? 0 : cur_j + 1;
    push_items(m, d, j0, n, fresh ? "R7" : "R8");
    cur_j = j0 + n - 1;
    cur_m = m;
    cur_d = d;
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset(logic [1:0] m, logic [1:0] d, int n);
    @(negedge clk);
    rst = 1'b1;
    mode_sel = m;
    div_sel = d;
    repeat (3) @(posedge clk);
    #2;
    check("R1", ph_out, exp_pat(m, 0));
    @(negedge clk);
    rst = 1'b0;
    push_items(m, d, 1, n, "R1");
    cur_j = n;
    cur_m = m;
    cur_d = d;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(2'b00, 2'b00, 6);
    run_cfg(2'b01, 2'b00, 9);
    run_cfg(2'b10, 2'b00, 8);
    run_cfg(2'b11, 2'b00, 6);
    run_cfg(2'b00, 2'b01, 45);
    run_cfg(2'b01, 2'b01, 30);   // next edge would carry a step (R7 collision)
    run_cfg(2'b10, 2'b01, 13);   // restart mid-hold
    run_cfg(2'b10, 2'b01, 40);   // same settings: R8 continuation
    run_cfg(2'b01, 2'b01, 35);
    run_cfg(2'b01, 2'b01, 20);   // R8 continuation across a step
    run_cfg(2'b10, 2'b10, 450);
    run_cfg(2'b00, 2'b10, 250);
    run_cfg(2'b01, 2'b11, 7);
    run_cfg(2'b11, 2'b01, 25);
    do_reset(2'b10, 2'b01, 30);
    do_reset(2'b01, 2'b10, 120);
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule